// File: doc/BRIEF.md
# Complementary PWM Output Stage with Break

This block turns the raw PWM reference of one timer channel into a main pad output and a complementary pad output. A programmable dead time separates the two waveforms. Each output has its own polarity, its own enable and its own pad output-enable. A master output enable gates the whole pair. While the master enable is clear, the pair enters a frozen state. In that state each enabled output either drives a programmed idle level or releases its pad, depending on a frozen-state select input.

The break path clears the master enable. A break comes from an external pin, through a synchronizer and a selectable active level, or from a single-cycle clock-failure strobe. A break-enable input gates both sources. Software sets the master enable again with a one-cycle set strobe. When automatic re-enable is on, a one-cycle counter-overflow strobe sets it instead. A break always beats a re-enable in the same cycle.

The reference and the events are continuous waveform and strobe signals, not a data stream. No valid/ready handshake applies, so every pin is a plain control or status wire with no back-pressure. All inputs are sampled on the rising edge of `clk`.

Top module: `pwm_pair_stage`

## Requirements
- R1: After reset, `moe_o` is 0 and the dead-time state holds the reference as low with a zero count.
- R2: With dead count D, when `ref_i` is first sampled high at edge k, the main internal active signal goes high after edge k+D. The complementary active signal goes low after edge k.
- R3: With dead count D, when `ref_i` is first sampled low at edge k, the complementary active signal goes high after edge k+D. The main active signal goes low after edge k.
- R4: While `moe_o` is 1 and both pads are enabled, the two outputs are never at their active levels together. An output is at its active level when `pad XOR its polarity input` is 1.
- R5: While `moe_o` is 1 and an output is enabled, its pad equals its internal active signal XOR its polarity input, and its pad enable is 1.
- R6: While an output's enable input is 0, its pad enable is 0. Its pad level is then its polarity input when `moe_o` is 1, and its idle input when `moe_o` is 0.
- R7: While `moe_o` is 0, `frz_drive_i` is 1 and an output is enabled, that output drives its idle input with its pad enable at 1.
- R8: While `moe_o` is 0 and `frz_drive_i` is 0, both pad enables are 0.
- R9: With `brk_en_i` at 1, a `clk_fail_i` strobe clears `moe_o` after the next edge. The break pin passes through two flops and is active high when `brk_pol_i` is 1 and active low when `brk_pol_i` is 0; a pin change clears `moe_o` after the third edge. With `brk_en_i` at 0, neither source has any effect.
- R10: A `moe_set_i` strobe sets `moe_o` after the next edge. An `ovf_i` strobe does the same only while `auto_en_i` is 1; with `auto_en_i` at 0 it is ignored.
- R11: When a break and a set or overflow re-enable occur in the same cycle, `moe_o` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_i | input | 1 | Raw PWM reference |
| dead_i | input | DT_W | Dead time in clock cycles |
| main_en_i | input | 1 | Main output enable |
| comp_en_i | input | 1 | Complementary output enable |
| main_pol_i | input | 1 | Main polarity (1 inverts) |
| comp_pol_i | input | 1 | Complementary polarity (1 inverts) |
| main_idle_i | input | 1 | Main idle level |
| comp_idle_i | input | 1 | Complementary idle level |
| frz_drive_i | input | 1 | Frozen state: 1 drives idle, 0 releases pads |
| brk_pin_i | input | 1 | External break pin (asynchronous) |
| brk_pol_i | input | 1 | Break pin active level (1 = high) |
| clk_fail_i | input | 1 | Clock-failure strobe |
| brk_en_i | input | 1 | Break enable |
| auto_en_i | input | 1 | Automatic re-enable on overflow |
| ovf_i | input | 1 | Counter overflow strobe |
| moe_set_i | input | 1 | Master enable set strobe |
| main_o | output | 1 | Main pad level |
| main_oe_o | output | 1 | Main pad output enable |
| comp_o | output | 1 | Complementary pad level |
| comp_oe_o | output | 1 | Complementary pad output enable |
| moe_o | output | 1 | Master output enable |

## Verification
A stuck or mis-loaded dead-time counter shows at the pads on the first reference edge. One output either rises too early, so that both outputs are active together, or never rises at all. Each cycle of the dead window is sampled so that an off-by-one is caught. A wrong master-enable state shows at `moe_o` and as idle or released pads one edge after a strobe, or three edges after a pin change. A wrong synchronizer depth or wrong break priority therefore shows within four cycles.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int unsigned CH_MAIN = 0;
  localparam int unsigned CH_COMP = 1;
  localparam int unsigned N_CH    = 2;

  typedef enum logic [1:0] {
    PAD_RUN  = 2'd0,
    PAD_IDLE = 2'd1,
    PAD_OFF  = 2'd2
  } pad_mode_e;
endpackage

// File: rtl/pwm_dead_time.sv
module pwm_dead_time #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dead_i,
  output logic [1:0]      act_o
);
  logic            ref_q;
  logic [DT_W-1:0] cnt_q;
  logic            settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      ref_q <= ref_i;
      if (ref_i != ref_q)
        cnt_q <= dead_i;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - DT_W'(1);
    end
  end

  assign settled  = (cnt_q == '0);
  assign act_o[0] = ref_q & settled;
  assign act_o[1] = ~ref_q & settled;

  // An edge with a nonzero dead time leaves both sides inactive
  assert_dead_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((ref_i != ref_q) && (dead_i != '0)) |=> (act_o == 2'b00));

  // A side only turns active while the reference sits on its level
  assert_main_follows_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_o[0]) |-> $past(ref_i));
endmodule

// File: rtl/pwm_break_ctrl.sv
module pwm_break_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_pin_i,
  input  logic brk_pol_i,
  input  logic clk_fail_i,
  input  logic brk_en_i,
  input  logic auto_en_i,
  input  logic ovf_i,
  input  logic moe_set_i,
  output logic moe_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic pin_hit, trip, rearm, moe_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sync_q[g] <= 1'b0;
      else if (g == 0) sync_q[g] <= brk_pin_i;
      else             sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  assign pin_hit = brk_pol_i ? sync_q[LAST] : ~sync_q[LAST];
  assign trip    = brk_en_i & (pin_hit | clk_fail_i);
  assign rearm   = moe_set_i | (auto_en_i & ovf_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     moe_q <= 1'b0;
    else if (trip)  moe_q <= 1'b0;
    else if (rearm) moe_q <= 1'b1;
  end

  assign moe_o = moe_q;

  assert_fail_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_en_i && clk_fail_i) |=> !moe_o);

  assert_break_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && (moe_set_i || ovf_i)) |=> !moe_o);

  assert_rise_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(moe_o) |-> $past(moe_set_i || (auto_en_i && ovf_i)));

  assert_stay_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!moe_o && !moe_set_i && !(auto_en_i && ovf_i)) |=> !moe_o);
endmodule

// File: rtl/pwm_pad_drive.sv
module pwm_pad_drive
  import pwm_pair_pkg::*;
(
  input  logic act_i,
  input  logic en_i,
  input  logic pol_i,
  input  logic idle_i,
  input  logic moe_i,
  input  logic frz_drive_i,
  output logic pad_o,
  output logic oe_o
);
  pad_mode_e mode;

  always_comb begin
    if (!en_i)            mode = PAD_OFF;
    else if (moe_i)       mode = PAD_RUN;
    else if (frz_drive_i) mode = PAD_IDLE;
    else                  mode = PAD_OFF;
  end

  always_comb begin
    unique case (mode)
      PAD_RUN:  pad_o = act_i ^ pol_i;
      PAD_IDLE: pad_o = idle_i;
      default:  pad_o = moe_i ? pol_i : idle_i;
    endcase
  end

  assign oe_o = (mode != PAD_OFF);
endmodule

// File: rtl/pwm_pair_stage.sv
module pwm_pair_stage
  import pwm_pair_pkg::*;
#(
  parameter int DT_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dead_i,
  input  logic            main_en_i,
  input  logic            comp_en_i,
  input  logic            main_pol_i,
  input  logic            comp_pol_i,
  input  logic            main_idle_i,
  input  logic            comp_idle_i,
  input  logic            frz_drive_i,
  input  logic            brk_pin_i,
  input  logic            brk_pol_i,
  input  logic            clk_fail_i,
  input  logic            brk_en_i,
  input  logic            auto_en_i,
  input  logic            ovf_i,
  input  logic            moe_set_i,
  output logic            main_o,
  output logic            main_oe_o,
  output logic            comp_o,
  output logic            comp_oe_o,
  output logic            moe_o
);
  logic [N_CH-1:0] act, en, pol, idle, pad, oe;

  assign en   = {comp_en_i, main_en_i};
  assign pol  = {comp_pol_i, main_pol_i};
  assign idle = {comp_idle_i, main_idle_i};

  pwm_dead_time #(.DT_W(DT_W)) u_dead (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .dead_i(dead_i), .act_o(act)
  );

  pwm_break_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_brk (
    .clk(clk), .rst_n(rst_n), .brk_pin_i(brk_pin_i), .brk_pol_i(brk_pol_i),
    .clk_fail_i(clk_fail_i), .brk_en_i(brk_en_i), .auto_en_i(auto_en_i),
    .ovf_i(ovf_i), .moe_set_i(moe_set_i), .moe_o(moe_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_pad
    pwm_pad_drive u_drv (
      .act_i(act[c]), .en_i(en[c]), .pol_i(pol[c]), .idle_i(idle[c]),
      .moe_i(moe_o), .frz_drive_i(frz_drive_i), .pad_o(pad[c]), .oe_o(oe[c])
    );
  end

  assign main_o    = pad[CH_MAIN];
  assign main_oe_o = oe[CH_MAIN];
  assign comp_o    = pad[CH_COMP];
  assign comp_oe_o = oe[CH_COMP];

  assert_pair_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (moe_o && main_oe_o && comp_oe_o) |-> !((main_o ^ main_pol_i) && (comp_o ^ comp_pol_i)));

  assert_idle_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!moe_o && main_en_i && frz_drive_i) |-> (main_oe_o && (main_o == main_idle_i)));

  assert_frozen_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!moe_o && !frz_drive_i) |-> (!main_oe_o && !comp_oe_o));

  assert_disabled_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_en_i || !comp_en_i) |-> !((!main_en_i && main_oe_o) || (!comp_en_i && comp_oe_o)));
endmodule

// File: tb/pwm_pair_stage_bench.sv
module pwm_pair_stage_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_i = 1'b0;
  logic [7:0] dead_i = 8'd0;
  logic main_en_i = 1'b1, comp_en_i = 1'b1;
  logic main_pol_i = 1'b0, comp_pol_i = 1'b0;
  logic main_idle_i = 1'b1, comp_idle_i = 1'b0;
  logic frz_drive_i = 1'b1;
  logic brk_pin_i = 1'b0, brk_pol_i = 1'b1, clk_fail_i = 1'b0, brk_en_i = 1'b0;
  logic auto_en_i = 1'b0, ovf_i = 1'b0, moe_set_i = 1'b0;
  logic main_o, main_oe_o, comp_o, comp_oe_o, moe_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_pair_stage u_pwm_pair_stage (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .dead_i(dead_i),
    .main_en_i(main_en_i), .comp_en_i(comp_en_i),
    .main_pol_i(main_pol_i), .comp_pol_i(comp_pol_i),
    .main_idle_i(main_idle_i), .comp_idle_i(comp_idle_i),
    .frz_drive_i(frz_drive_i), .brk_pin_i(brk_pin_i), .brk_pol_i(brk_pol_i),
    .clk_fail_i(clk_fail_i), .brk_en_i(brk_en_i), .auto_en_i(auto_en_i),
    .ovf_i(ovf_i), .moe_set_i(moe_set_i),
    .main_o(main_o), .main_oe_o(main_oe_o), .comp_o(comp_o),
    .comp_oe_o(comp_oe_o), .moe_o(moe_o)
  );

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: %s got %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_set();
    moe_set_i = 1'b1; tick(1); moe_set_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "moe_o after reset", moe_o, 1'b0);
    chk("R7", "main_oe idle", main_oe_o, 1'b1);
    chk("R7", "main_o idle", main_o, 1'b1);
    chk("R7", "comp_o idle", comp_o, 1'b0);
    frz_drive_i = 1'b0; tick(1);
    chk("R8", "main_oe released", main_oe_o, 1'b0);
    chk("R8", "comp_oe released", comp_oe_o, 1'b0);
    frz_drive_i = 1'b1;
  endtask

  task automatic t_set();
    pulse_set();
    chk("R10", "moe_o after set strobe", moe_o, 1'b1);
    chk("R1", "reset ref low: comp active", comp_o, 1'b1);
    chk("R1", "reset ref low: main inactive", main_o, 1'b0);
  endtask

  task automatic t_dead(input int d);
    dead_i = 8'(d);
    ref_i = 1'b1;
    for (int i = 1; i <= d + 1; i++) begin
      tick(1);
      chk("R2", "main_o during rise", main_o, (i == d + 1));
      chk("R2", "comp_o during rise", comp_o, 1'b0);
      chk("R4", "no overlap rise", main_o & comp_o, 1'b0);
    end
    tick(2);
    ref_i = 1'b0;
    for (int i = 1; i <= d + 1; i++) begin
      tick(1);
      chk("R3", "comp_o during fall", comp_o, (i == d + 1));
      chk("R3", "main_o during fall", main_o, 1'b0);
      chk("R4", "no overlap fall", main_o & comp_o, 1'b0);
    end
    tick(2);
  endtask

  task automatic t_polarity();
    main_pol_i = 1'b1; comp_pol_i = 1'b1; tick(1);
    chk("R5", "main_o inverted", main_o, 1'b1);
    chk("R5", "comp_o inverted", comp_o, 1'b0);
    chk("R5", "main_oe running", main_oe_o, 1'b1);
    main_pol_i = 1'b0; comp_pol_i = 1'b0;
  endtask

  task automatic t_disable();
    main_en_i = 1'b0; main_pol_i = 1'b1; tick(1);
    chk("R6", "main_oe disabled", main_oe_o, 1'b0);
    chk("R6", "main_o inactive level", main_o, 1'b1);
    chk("R6", "comp_oe unaffected", comp_oe_o, 1'b1);
    main_en_i = 1'b1; main_pol_i = 1'b0;
  endtask

  task automatic t_brk_gated();
    brk_en_i = 1'b0; clk_fail_i = 1'b1; tick(1); clk_fail_i = 1'b0;
    chk("R9", "fail ignored with break off", moe_o, 1'b1);
  endtask

  task automatic t_brk_fail();
    brk_en_i = 1'b1; clk_fail_i = 1'b1; tick(1); clk_fail_i = 1'b0;
    chk("R9", "moe_o cleared by clock fail", moe_o, 1'b0);
    chk("R9", "main_o forced idle", main_o, 1'b1);
    chk("R9", "comp_o forced idle", comp_o, 1'b0);
  endtask

  task automatic t_auto();
    auto_en_i = 1'b0; ovf_i = 1'b1; tick(1); ovf_i = 1'b0;
    chk("R10", "ovf ignored without auto", moe_o, 1'b0);
    auto_en_i = 1'b1; ovf_i = 1'b1; tick(1); ovf_i = 1'b0;
    chk("R10", "ovf re-enables", moe_o, 1'b1);
  endtask

  task automatic t_priority();
    clk_fail_i = 1'b1; ovf_i = 1'b1; moe_set_i = 1'b1; tick(1);
    clk_fail_i = 1'b0; ovf_i = 1'b0; moe_set_i = 1'b0;
    chk("R11", "break beats re-enable from set", moe_o, 1'b0);
    clk_fail_i = 1'b1; ovf_i = 1'b1; tick(1);
    clk_fail_i = 1'b0; ovf_i = 1'b0;
    chk("R11", "break beats re-enable while low", moe_o, 1'b0);
    auto_en_i = 1'b0;
  endtask

  task automatic t_pin_high();
    pulse_set();
    brk_pol_i = 1'b1; brk_pin_i = 1'b1;
    tick(1); chk("R9", "pin edge 1", moe_o, 1'b1);
    tick(1); chk("R9", "pin edge 2", moe_o, 1'b1);
    tick(1); chk("R9", "pin edge 3", moe_o, 1'b0);
    pulse_set();
    chk("R11", "held pin beats set", moe_o, 1'b0);
    brk_pin_i = 1'b0; tick(3);
    pulse_set();
    chk("R10", "set after pin release", moe_o, 1'b1);
  endtask

  task automatic t_pin_low();
    brk_en_i = 1'b0; brk_pol_i = 1'b0; brk_pin_i = 1'b1; tick(3);
    brk_en_i = 1'b1; tick(1);
    chk("R9", "low-active pin idle high", moe_o, 1'b1);
    brk_pin_i = 1'b0;
    tick(2); chk("R9", "low pin edge 2", moe_o, 1'b1);
    tick(1); chk("R9", "low pin edge 3", moe_o, 1'b0);
    brk_pin_i = 1'b1; brk_en_i = 1'b0; brk_pol_i = 1'b1; tick(3);
    brk_pin_i = 1'b0; tick(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete got hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_set();
    t_dead(3);
    t_dead(0);
    t_dead(1);
    t_polarity();
    t_disable();
    t_brk_gated();
    t_brk_fail();
    t_auto();
    t_priority();
    t_pin_high();
    t_pin_low();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule